// File: doc/BRIEF.md
# Instrument Status Reporting Unit

This block keeps the status state of a programmable instrument that answers a remote controller. Error, completion and power-on events arrive as single-cycle pulses. They stick in an 8-bit event register. A programmable enable mask folds that register into one summary bit. The summary bit joins a message-available flag and other summary inputs from elsewhere in the instrument to form a status byte. A second programmable mask folds the status byte into a master summary. A rising master summary raises a service request line to the controller.

The status byte can be read in two ways. The query view is combinational: it shows the live master summary in bit 6 and changes no state. The serial poll view shows the latched service request in bit 6. A poll strobe clears that latch and nothing else. A clear-status strobe empties the event register. When the clear arrives right after a message terminator, the block also pulses a clear request toward the output queue.

All ports are plain control and status pins. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. Each write or strobe acts on the clock edge where it is high.

Top module: `status_report_unit`

## Requirements
- R1: When reset is released, the event register reads 8'h80 (power-on flag, bit 7, set). The enable masks read their reset parameters, which default to 8'h00. `srq` is 0.
- R2: A high `evt_pulse[k]` sets event register bit k on the next edge. The bit stays set until a clear-status. Bits 6 and 1 always read 0.
- R3: A write to the event enable mask is visible on `ese_rd_data` after the edge. Status byte bit 5 is 1 exactly when (event register AND event enable) is non-zero.
- R4: Status byte bits 7 and 3..0 follow `ext_sum` bits 7 and 3..0. Bit 4 follows `mav_in`. `ext_sum` bits 6..4 have no effect.
- R5: The request enable mask stores written data with bit 6 forced to 0. The master summary is 1 when any status byte bit other than bit 6 is 1 together with its request enable bit. `query_byte` bit 6 shows the master summary with no delay, and reading the query view changes no state.
- R6: `srq` becomes 1 one edge after the master summary goes from 0 to 1. It stays 1 while no poll strobe arrives.
- R7: `poll_byte` equals `query_byte` except that bit 6 carries `srq`. A poll strobe clears `srq` on the next edge and leaves all other state unchanged. If the master summary rises in the same cycle as the strobe, `srq` ends up 1.
- R8: After a poll clears `srq`, it does not return while the master summary stays 1. It returns only after the summary goes to 0 and then back to 1.
- R9: A clear-status strobe empties the event register on the next edge, including the power-on bit. An event pulse in the same cycle still sets its bit. Status byte bits 4, 7 and 3..0 are unaffected.
- R10: `clr_oq` is 1 in the same cycle exactly when `cls_strobe` and `cls_after_term` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 8 | Event pulses, one bit per event register bit |
| ese_wr_en | input | 1 | Write strobe for the event enable mask |
| ese_wr_data | input | 8 | Event enable write data |
| ese_rd_data | output | 8 | Event enable mask readback |
| sre_wr_en | input | 1 | Write strobe for the request enable mask |
| sre_wr_data | input | 8 | Request enable write data |
| sre_rd_data | output | 8 | Request enable mask readback (bit 6 is always 0) |
| esr_value | output | 8 | Event register contents |
| ext_sum | input | 8 | External summary bits (7 and 3..0 are used) |
| mav_in | input | 1 | Output queue not empty |
| query_byte | output | 8 | Status byte with the master summary in bit 6 |
| poll_byte | output | 8 | Status byte with the request latch in bit 6 |
| poll_strobe | input | 1 | Serial poll done; clears the request latch |
| srq | output | 1 | Service request line |
| cls_strobe | input | 1 | Clear-status command |
| cls_after_term | input | 1 | Clear-status follows a message terminator |
| clr_oq | output | 1 | Clear request to the output queue |

## Verification
The hardest state to reach is a cleared request latch while the master summary is still high. Nothing at the ports shows the difference between a latch that is waiting to re-arm and one that is simply idle. The bench gets there by enabling a single external summary bit and raising it. It then polls and holds the summary high for several cycles to confirm `srq` stays low. Next it drops the summary and raises it again, and finally raises it on the same edge as a poll strobe. Sweeps over every mask value against fixed event and summary patterns cover the two masking stages.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_W = 8;
  // event register bits that never set
  localparam logic [SR_W-1:0] ESR_RSVD  = 8'h42;
  localparam logic [SR_W-1:0] ESR_RESET = 8'h80;
  // status byte bit positions
  localparam int STB_RQ  = 6;
  localparam int STB_ESB = 5;
  localparam int STB_MAV = 4;
  // request enable bit that is not storable
  localparam logic [SR_W-1:0] SRE_ZERO = 8'h40;
endpackage

// File: rtl/sr_event_reg.sv
module sr_event_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RSVD = '0,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign q[i] = 1'b0;
    end else begin : g_live
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= RST[i];
        else        b_q <= (b_q & ~clr) | evt[i];
      end
      assign q[i] = b_q;
    end
  end
endmodule

// File: rtl/sr_mask_reg.sv
module sr_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] ZERO = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] m_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     m_q <= RST & ~ZERO;
    else if (wr_en) m_q <= wr_data & ~ZERO;
  end
  assign q = m_q;
endmodule

// File: rtl/sr_service.sv
module sr_service
  import sr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SR_W-1:0] esr,
  input  logic [SR_W-1:0] ese,
  input  logic [SR_W-1:0] sre,
  input  logic [SR_W-1:0] ext_sum,
  input  logic            mav,
  input  logic            poll_clr,
  output logic [SR_W-1:0] query_byte,
  output logic [SR_W-1:0] poll_byte,
  output logic            rqs
);
  localparam logic [SR_W-1:0] EXT_USE =
    ~((SR_W'(1) << STB_RQ) | (SR_W'(1) << STB_ESB) | (SR_W'(1) << STB_MAV));

  logic            esb;
  logic            mss;
  logic            mss_q;
  logic            rqs_q;
  logic [SR_W-1:0] base;

  always_comb begin
    esb  = |(esr & ese);
    base = ext_sum & EXT_USE;
    base[STB_ESB] = esb;
    base[STB_MAV] = mav;
    mss  = |(base & sre);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss;
      rqs_q <= (mss & ~mss_q) | (rqs_q & ~poll_clr);
    end
  end

  always_comb begin
    query_byte = base;
    query_byte[STB_RQ] = mss;
    poll_byte  = base;
    poll_byte[STB_RQ]  = rqs_q;
  end
  assign rqs = rqs_q;
endmodule

// File: rtl/status_report_unit.sv
module status_report_unit
  import sr_pkg::*;
#(
  parameter logic [7:0] ESE_RESET = 8'h00,
  parameter logic [7:0] SRE_RESET = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_pulse,
  input  logic       ese_wr_en,
  input  logic [7:0] ese_wr_data,
  output logic [7:0] ese_rd_data,
  input  logic       sre_wr_en,
  input  logic [7:0] sre_wr_data,
  output logic [7:0] sre_rd_data,
  output logic [7:0] esr_value,
  input  logic [7:0] ext_sum,
  input  logic       mav_in,
  output logic [7:0] query_byte,
  output logic [7:0] poll_byte,
  input  logic       poll_strobe,
  output logic       srq,
  input  logic       cls_strobe,
  input  logic       cls_after_term,
  output logic       clr_oq
);
  sr_event_reg #(.W(SR_W), .RSVD(ESR_RSVD), .RST(ESR_RESET)) u_esr (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(cls_strobe), .q(esr_value)
  );

  sr_mask_reg #(.W(SR_W), .RST(ESE_RESET), .ZERO('0)) u_ese (
    .clk(clk), .rst_n(rst_n), .wr_en(ese_wr_en), .wr_data(ese_wr_data), .q(ese_rd_data)
  );

  sr_mask_reg #(.W(SR_W), .RST(SRE_RESET), .ZERO(SRE_ZERO)) u_sre (
    .clk(clk), .rst_n(rst_n), .wr_en(sre_wr_en), .wr_data(sre_wr_data), .q(sre_rd_data)
  );

  sr_service u_svc (
    .clk(clk), .rst_n(rst_n), .esr(esr_value), .ese(ese_rd_data), .sre(sre_rd_data),
    .ext_sum(ext_sum), .mav(mav_in), .poll_clr(poll_strobe),
    .query_byte(query_byte), .poll_byte(poll_byte), .rqs(srq)
  );

  assign clr_oq = cls_strobe & cls_after_term;
endmodule

// File: rtl/status_report_unit_chk.sv
module status_report_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] evt_pulse,
  input logic [7:0] esr_value,
  input logic [7:0] query_byte,
  input logic       poll_strobe,
  input logic       srq,
  input logic       cls_strobe
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse[6] || evt_pulse[1]) |=> (esr_value[6] == 1'b0 && esr_value[1] == 1'b0));

  // R2
  event_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_pulse & 8'hBD) != 8'h00) |=>
      ((esr_value & $past(evt_pulse & 8'hBD)) == $past(evt_pulse & 8'hBD)));

  // R2
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_strobe |=> ((esr_value & $past(esr_value)) == $past(esr_value)));

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_strobe && evt_pulse == 8'h00) |=> (esr_value == 8'h00));

  // R6
  request_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (query_byte[6] && !$past(query_byte[6])) |=> srq);

  // R7
  poll_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_strobe && !query_byte[6]) |=> !srq);

  // R8
  rearm_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srq) |-> ($past(query_byte[6]) && !$past(query_byte[6], 2)));
endmodule

bind status_report_unit status_report_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .esr_value(esr_value),
  .query_byte(query_byte), .poll_strobe(poll_strobe), .srq(srq), .cls_strobe(cls_strobe)
);

// File: tb/status_report_unit_test.sv
`timescale 1ns/1ps
module status_report_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_pulse;
  logic       ese_wr_en;
  logic [7:0] ese_wr_data;
  logic [7:0] ese_rd_data;
  logic       sre_wr_en;
  logic [7:0] sre_wr_data;
  logic [7:0] sre_rd_data;
  logic [7:0] esr_value;
  logic [7:0] ext_sum;
  logic       mav_in;
  logic [7:0] query_byte;
  logic [7:0] poll_byte;
  logic       poll_strobe;
  logic       srq;
  logic       cls_strobe;
  logic       cls_after_term;
  logic       clr_oq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  status_report_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .ese_wr_en(ese_wr_en), .ese_wr_data(ese_wr_data), .ese_rd_data(ese_rd_data),
    .sre_wr_en(sre_wr_en), .sre_wr_data(sre_wr_data), .sre_rd_data(sre_rd_data),
    .esr_value(esr_value), .ext_sum(ext_sum), .mav_in(mav_in),
    .query_byte(query_byte), .poll_byte(poll_byte), .poll_strobe(poll_strobe),
    .srq(srq), .cls_strobe(cls_strobe), .cls_after_term(cls_after_term), .clr_oq(clr_oq)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_cls();
    cls_strobe = 1'b1; cyc(); cls_strobe = 1'b0;
  endtask

  task automatic wr_ese(input logic [7:0] v);
    ese_wr_en = 1'b1; ese_wr_data = v; cyc(); ese_wr_en = 1'b0;
  endtask

  task automatic wr_sre(input logic [7:0] v);
    sre_wr_en = 1'b1; sre_wr_data = v; cyc(); sre_wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] acc, p, e_esr, v, base, exp_q;
    rst_n = 1'b0; evt_pulse = '0; ese_wr_en = 0; ese_wr_data = '0;
    sre_wr_en = 0; sre_wr_data = '0; ext_sum = '0; mav_in = 0;
    poll_strobe = 0; cls_strobe = 0; cls_after_term = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 esr", esr_value, 8'h80);
    chk("R1 ese", ese_rd_data, 8'h00);
    chk("R1 sre", sre_rd_data, 8'h00);
    chk("R1 srq", {7'd0, srq}, 8'h00);
    chk("R1 query", query_byte, 8'h00);

    // R9 clear removes power-on flag
    pulse_cls();
    chk("R9 pon cleared", esr_value, 8'h00);

    // R2 each event bit in turn, sticky accumulation
    acc = 8'h00;
    for (int k = 0; k < 8; k++) begin
      evt_pulse = 8'(1 << k); cyc(); evt_pulse = '0;
      acc = acc | (8'(1 << k) & 8'hBD);
      chk("R2 accumulate", esr_value, acc);
    end
    repeat (3) cyc();
    chk("R2 sticky", esr_value, acc);

    // R4 sweep of external summary bits and message-available
    pulse_cls();
    for (int i = 0; i < 256; i++) begin
      ext_sum = 8'(i); mav_in = ^ext_sum;
      #1;
      exp_q = (8'(i) & 8'h8F) | {3'b000, mav_in, 4'b0000};
      chk("R4 status byte", query_byte, exp_q);
    end
    ext_sum = '0; mav_in = 0;

    // R3 event enable sweep against several event patterns
    for (int i = 0; i < 8; i++) begin
      p = 8'(i * 37 + 5);
      pulse_cls();
      evt_pulse = p; cyc(); evt_pulse = '0;
      e_esr = p & 8'hBD;
      chk("R2 pattern", esr_value, e_esr);
      for (int e = 0; e < 256; e++) begin
        wr_ese(8'(e));
        chk("R3 readback", ese_rd_data, 8'(e));
        chk("R3 summary", {7'd0, query_byte[5]}, {7'd0, |(e_esr & 8'(e))});
      end
    end

    // R5 request enable sweep against single external bits
    pulse_cls();
    wr_ese(8'h00);
    for (int j = 0; j < 9; j++) begin
      v = (j == 8) ? 8'h00 : 8'(1 << j);
      ext_sum = v;
      for (int s = 0; s < 256; s++) begin
        wr_sre(8'(s));
        chk("R5 readback", sre_rd_data, 8'(s) & 8'hBF);
        base = v & 8'h8F;
        chk("R5 master", {7'd0, query_byte[6]}, {7'd0, |(base & 8'(s) & 8'hBF)});
      end
    end
    ext_sum = '0;

    // R5 event summary reaching the master summary
    wr_ese(8'h04); wr_sre(8'h20);
    evt_pulse = 8'h04; cyc(); evt_pulse = '0;
    chk("R5 esb to master", query_byte, 8'h60);

    // prepare the request latch
    wr_sre(8'h00); wr_ese(8'h00); pulse_cls();
    poll_strobe = 1'b1; cyc(); poll_strobe = 1'b0;
    cyc();
    chk("R7 idle", {7'd0, srq}, 8'h00);

    // R6 rise of the master summary
    wr_sre(8'h01);
    ext_sum = 8'h01;
    #1;
    chk("R6 before edge", {7'd0, srq}, 8'h00);
    chk("R5 live query", query_byte, 8'h41);
    cyc();
    chk("R6 after edge", {7'd0, srq}, 8'h01);
    repeat (3) cyc();
    chk("R6 held", {7'd0, srq}, 8'h01);
    chk("R7 poll view", poll_byte, 8'h41);

    // R7 poll clears only the latch
    poll_strobe = 1'b1; cyc(); poll_strobe = 1'b0;
    chk("R7 srq cleared", {7'd0, srq}, 8'h00);
    chk("R7 poll view after", poll_byte, 8'h01);
    chk("R7 query unchanged", query_byte, 8'h41);

    // R8 no re-assertion while summary stays high
    repeat (4) cyc();
    chk("R8 stays low", {7'd0, srq}, 8'h00);
    ext_sum = 8'h00; cyc();
    chk("R8 summary low", {7'd0, srq}, 8'h00);
    ext_sum = 8'h01; cyc();
    chk("R8 re-armed", {7'd0, srq}, 8'h01);

    // R7 coincident rise and poll: set wins
    ext_sum = 8'h00; cyc();
    ext_sum = 8'h01; poll_strobe = 1'b1; cyc(); poll_strobe = 1'b0;
    chk("R7 set wins", {7'd0, srq}, 8'h01);

    // R9 clear with a same-cycle event; other bits untouched
    wr_sre(8'h00);
    mav_in = 1'b1;
    evt_pulse = 8'h08; cyc(); evt_pulse = '0;
    cls_strobe = 1'b1; evt_pulse = 8'h04; cyc(); cls_strobe = 1'b0; evt_pulse = '0;
    chk("R9 event survives clear", esr_value, 8'h04);
    chk("R9 other bits kept", query_byte & 8'h9F, 8'h11);

    // R10 output queue clear strobe
    cls_strobe = 1'b1; cls_after_term = 1'b1; #1;
    chk("R10 both", {7'd0, clr_oq}, 8'h01);
    cls_after_term = 1'b0; #1;
    chk("R10 no terminator", {7'd0, clr_oq}, 8'h00);
    cls_strobe = 1'b0; cls_after_term = 1'b1; #1;
    chk("R10 no clear", {7'd0, clr_oq}, 8'h00);
    cls_after_term = 1'b0;
    cyc();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule